// File: doc/BRIEF.md
# Dual-Output Interrupt Controller

This block collects 95 level-sensitive interrupt sources into three 32-bit banks. Source n lives in bank n/32 at bit n%32. Each source first passes through a two-flop synchronizer. A high level then sets a sticky pending bit, and only software clears that bit, by writing ones to it. The block drives two processor lines. The normal request is raised by any pending source that is not masked. The fast request is raised by the subset of those sources that a per-bit select register routes to it.

Software reaches the block through a single-cycle register port with a 32-bit data path and a 1 KB byte-addressed window. The port has a request strobe and a write flag. Write data takes effect at the clock edge where both are high. Read data is combinational from the address while the request is high and the write flag is low. Alongside the bank arrays there are four control words: an interrupt vector, a base address, a protect word and a non-maskable control word. The block stores these words and reads them back, and nothing else in the block uses them.

Top module: `dual_line_intc`

## Requirements
- R1: After reset, every mapped register reads zero, and irq_o and fiq_o are low.
- R2: Source n sets bit n%32 of the pending bank at offset 0x10 + 4*(n/32). The bit reads one after the third rising clock edge following the input going high, and reads zero after only two edges.
- R3: A pending bit stays set after its source returns low, until software clears it.
- R4: A write to a pending bank (0x10, 0x14, 0x18) clears each bit that is one in the write data and leaves every other bit unchanged.
- R5: If the synchronized source is still high on the edge where its pending bit is cleared, the bit stays set.
- R6: irq_o is high exactly when some bank holds a bit that is pending and clear in the mask bank (0x50, 0x54, 0x58; a mask bit of one blocks its source).
- R7: fiq_o is high exactly when some bank holds a bit that is pending, clear in the mask bank and set in the select bank (0x30, 0x34, 0x38).
- R8: The vector word (0x00) and the base word (0x04) store write data with bits [1:0] forced to zero. The protect word (0x08) and the non-maskable control word (0x0C) store all 32 bits. A write to one control word leaves the other three unchanged.
- R9: The select, enable (0x40, 0x44, 0x48) and mask banks read back the last value written, all 32 bits. The enable banks have no effect on irq_o or fiq_o.
- R10: The fast-pending banks (0x20, 0x24, 0x28) read zero. Writes to them change no state.
- R11: An access whose address has non-zero bits [1:0], or that falls on bank index 3 of an array region (0x1C, 0x2C, ...), or at or above 0x60, reads zero and changes no state when written.
- R12: Bit 31 of bank 2 has no source. It always reads zero in the pending bank and never raises irq_o or fiq_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_i | input | 95 | Level-sensitive interrupt sources, bit n is source n |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 10 | Byte address within the 1 KB window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while req_i is high and we_i is low |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A single source raised at a known edge pins down the synchronizer latency and tells a two-stage delay apart from a one- or three-stage one. The source is then dropped to show the bit is sticky. A source held high across its own clear write separates set-wins priority from clear-wins priority, and a partial clear pattern shows that zero bits of the write data are left alone. All sources are driven at once so the bank edges show up, including the missing bit 31 of bank 2. A bank 2 case that selects and unmasks only bit 31 must raise neither line. Random sparse source patterns are interleaved with random mask, select, clear and arbitrary-address writes and compared against a bench model. These mixes tell apart the IRQ and FIQ combinations, mask polarity, aliasing of unmapped offsets, and fall-through between the control words.

// File: rtl/dli_pkg.sv
`timescale 1ns/1ps
package dli_pkg;
  // Region codes taken from byte-address bits [9:4]
  localparam int RG_CTRL  = 0;
  localparam int RG_IPEND = 1;
  localparam int RG_FPEND = 2;
  localparam int RG_SEL   = 3;
  localparam int RG_EN    = 4;
  localparam int RG_MASK  = 5;
  // Word codes inside the control region, address bits [3:2]
  localparam logic [1:0] CW_VEC  = 2'd0;
  localparam logic [1:0] CW_BASE = 2'd1;
  localparam logic [1:0] CW_PROT = 2'd2;
  localparam logic [1:0] CW_NMI  = 2'd3;
endpackage

// File: rtl/dli_rst_sync.sv
`timescale 1ns/1ps
module dli_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stg_q   <= 1'b0;
      rst_n_o <= 1'b0;
    end else begin
      stg_q   <= 1'b1;
      rst_n_o <= stg_q;
    end
  end
endmodule

// File: rtl/dli_sync.sv
`timescale 1ns/1ps
module dli_sync #(
  parameter int W = 95
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/dli_bank.sv
`timescale 1ns/1ps
module dli_bank #(
  parameter int DW   = 32,
  parameter int LIVE = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] src_i,
  input  logic          wr_pend_i,
  input  logic          wr_sel_i,
  input  logic          wr_en_i,
  input  logic          wr_mask_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] pend_o,
  output logic [DW-1:0] sel_o,
  output logic [DW-1:0] en_o,
  output logic [DW-1:0] mask_o,
  output logic          irq_o,
  output logic          fiq_o
);
  localparam logic [DW-1:0] LIVE_MASK = DW'((64'd1 << LIVE) - 64'd1);

  logic [DW-1:0] pend_q, pend_d, clr_vec;
  logic [DW-1:0] sel_q, en_q, mask_q;

  // Next state: clear by write-one, set by source; set wins
  always_comb begin
    clr_vec = wr_pend_i ? wdata_i : '0;
    pend_d  = ((pend_q & ~clr_vec) | src_i) & LIVE_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      sel_q  <= '0;
      en_q   <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (wr_sel_i)  sel_q  <= wdata_i;
      if (wr_en_i)   en_q   <= wdata_i;
      if (wr_mask_i) mask_q <= wdata_i;
    end
  end

  assign pend_o = pend_q;
  assign sel_o  = sel_q;
  assign en_o   = en_q;
  assign mask_o = mask_q;
  assign irq_o  = |(pend_q & ~mask_q);
  assign fiq_o  = |(pend_q & ~mask_q & sel_q);

  // R12: bits without a source never become pending
  p_no_phantom_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~LIVE_MASK) == '0);

  // R3: pending bits not cleared by a write survive the edge
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend_q) & ~$past(clr_vec)) & ~pend_q) == '0));

  // R2: a live synchronized source is pending one edge later
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_i & LIVE_MASK)) |=> ((($past(src_i) & LIVE_MASK) & ~pend_q) == '0));

  // R5: a clear that meets an active source leaves something pending
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend_i && (|(src_i & wdata_i & LIVE_MASK))) |=> (|pend_q));
endmodule

// File: rtl/dual_line_intc.sv
`timescale 1ns/1ps
module dual_line_intc #(
  parameter int NUM_SRC = 95,
  parameter int DW      = 32,
  parameter int AW      = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);
  import dli_pkg::*;

  localparam int BANKS = (NUM_SRC + DW - 1) / DW;
  localparam int PADW  = BANKS * DW;
  localparam int RW    = AW - 4;

  logic          rst_sync_n;
  logic [NUM_SRC-1:0] src_sync;
  logic [PADW-1:0]    src_pad;

  logic [RW-1:0] region;
  logic [1:0]    bsel;
  logic          aligned, wr, ctrl_wr, hit;
  logic [DW-1:0] rd_val;

  logic [DW-1:0] b_pend [BANKS];
  logic [DW-1:0] b_sel  [BANKS];
  logic [DW-1:0] b_en   [BANKS];
  logic [DW-1:0] b_mask [BANKS];
  logic [BANKS-1:0] b_irq, b_fiq;

  logic [DW-1:0] vec_q, vec_d, base_q, base_d, prot_q, prot_d, nmi_q, nmi_d;

  dli_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(rst_sync_n));

  dli_sync #(.W(NUM_SRC)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(src_i), .q_o(src_sync));

  always_comb begin
    src_pad = '0;
    src_pad[NUM_SRC-1:0] = src_sync;
  end

  // Address decode
  assign region  = addr_i[AW-1:4];
  assign bsel    = addr_i[3:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr      = req_i & we_i;
  assign ctrl_wr = wr & aligned & (region == RW'(RG_CTRL));

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam int LIVE = (b == BANKS - 1) ? (NUM_SRC - b * DW) : DW;
    logic wsel_b;
    assign wsel_b = wr & aligned & (bsel == 2'(b));

    dli_bank #(.DW(DW), .LIVE(LIVE)) u_bank (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .src_i     (src_pad[b*DW +: DW]),
      .wr_pend_i (wsel_b & (region == RW'(RG_IPEND))),
      .wr_sel_i  (wsel_b & (region == RW'(RG_SEL))),
      .wr_en_i   (wsel_b & (region == RW'(RG_EN))),
      .wr_mask_i (wsel_b & (region == RW'(RG_MASK))),
      .wdata_i   (wdata_i),
      .pend_o    (b_pend[b]),
      .sel_o     (b_sel[b]),
      .en_o      (b_en[b]),
      .mask_o    (b_mask[b]),
      .irq_o     (b_irq[b]),
      .fiq_o     (b_fiq[b])
    );
  end

  // Control words: next state
  always_comb begin
    vec_d  = vec_q;
    base_d = base_q;
    prot_d = prot_q;
    nmi_d  = nmi_q;
    if (ctrl_wr) begin
      unique case (bsel)
        CW_VEC:  vec_d  = wdata_i & ~DW'(3);
        CW_BASE: base_d = wdata_i & ~DW'(3);
        CW_PROT: prot_d = wdata_i;
        CW_NMI:  nmi_d  = wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vec_q  <= '0;
      base_q <= '0;
      prot_q <= '0;
      nmi_q  <= '0;
    end else if (ctrl_wr) begin
      vec_q  <= vec_d;
      base_q <= base_d;
      prot_q <= prot_d;
      nmi_q  <= nmi_d;
    end
  end

  // Read mux
  always_comb begin
    logic [DW-1:0] p, s, e, m;
    logic          bank_ok;
    p = '0; s = '0; e = '0; m = '0; bank_ok = 1'b0;
    for (int k = 0; k < BANKS; k++) begin
      if (bsel == 2'(k)) begin
        bank_ok = 1'b1;
        p = b_pend[k];
        s = b_sel[k];
        e = b_en[k];
        m = b_mask[k];
      end
    end
    hit    = 1'b0;
    rd_val = '0;
    if (aligned) begin
      if (region == RW'(RG_CTRL)) begin
        hit = 1'b1;
        unique case (bsel)
          CW_VEC:  rd_val = vec_q;
          CW_BASE: rd_val = base_q;
          CW_PROT: rd_val = prot_q;
          CW_NMI:  rd_val = nmi_q;
          default: ;
        endcase
      end else if (bank_ok) begin
        if (region == RW'(RG_IPEND)) begin hit = 1'b1; rd_val = p; end
        if (region == RW'(RG_FPEND)) begin hit = 1'b1; rd_val = '0; end
        if (region == RW'(RG_SEL))   begin hit = 1'b1; rd_val = s; end
        if (region == RW'(RG_EN))    begin hit = 1'b1; rd_val = e; end
        if (region == RW'(RG_MASK))  begin hit = 1'b1; rd_val = m; end
      end
    end
  end

  assign rdata_o = (req_i && !we_i) ? rd_val : '0;
  assign irq_o   = |b_irq;
  assign fiq_o   = |b_fiq;

  // R7: every fast request source is also a normal request source
  p_fiq_implies_irq_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fiq_o |-> irq_o);

  // R11: reads outside the map return zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && !we_i && !hit) |-> (rdata_o == '0));

  // R8: stored vector and base words stay word aligned
  p_align_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vec_q[1:0] == 2'b00) && (base_q[1:0] == 2'b00));

  // R8: control words change only on a control write
  p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctrl_wr |=> ($stable(prot_q) && $stable(nmi_q)));
endmodule

// File: tb/sim_dual_line_intc.sv
`timescale 1ns/1ps
module sim_dual_line_intc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [94:0] src;
  logic        req, we;
  logic [9:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq, fiq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // Bench model of software-visible state
  logic [31:0] m_pend [3];
  logic [31:0] m_sel  [3];
  logic [31:0] m_en   [3];
  logic [31:0] m_mask [3];
  logic [31:0] m_ctl  [4];

  always #2.5 clk = ~clk;

  dual_line_intc u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq));

  function automatic logic [31:0] live(input int b);
    return (b == 2) ? 32'h7FFF_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic f_irq();
    logic r = 1'b0;
    for (int b = 0; b < 3; b++) r |= |(m_pend[b] & ~m_mask[b]);
    return r;
  endfunction

  function automatic logic f_fiq();
    logic r = 1'b0;
    for (int b = 0; b < 3; b++) r |= |(m_pend[b] & ~m_mask[b] & m_sel[b]);
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [9:0] a);
    int rg = int'(a[9:4]);
    int b  = int'(a[3:2]);
    if (a[1:0] != 2'b00) return 32'h0;
    if (rg == 0) return m_ctl[b];
    if (b > 2) return 32'h0;
    case (rg)
      1: return m_pend[b];
      3: return m_sel[b];
      4: return m_en[b];
      5: return m_mask[b];
      default: return 32'h0;
    endcase
  endfunction

  task automatic mdl_wr(input logic [9:0] a, input logic [31:0] d);
    int rg = int'(a[9:4]);
    int b  = int'(a[3:2]);
    if (a[1:0] != 2'b00) return;
    if (rg == 0) begin
      m_ctl[b] = (b < 2) ? (d & 32'hFFFF_FFFC) : d;
    end else if (b <= 2) begin
      case (rg)
        1: m_pend[b] = m_pend[b] & ~d;
        3: m_sel[b]  = d;
        4: m_en[b]   = d;
        5: m_mask[b] = d;
        default: ;
      endcase
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic peek(input logic [9:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    mdl_wr(a, d);
  endtask

  task automatic raise(input logic [94:0] v);
    @(negedge clk);
    src = v;
    repeat (3) @(negedge clk);
    src = '0;
    repeat (3) @(negedge clk);
    for (int b = 0; b < 3; b++)
      m_pend[b] |= 32'({1'b0, v} >> (32 * b)) & live(b);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4711));
    src = '0; req = 0; we = 0; addr = '0; wdata = '0; rst_n = 1'b0;
    for (int b = 0; b < 3; b++) begin
      m_pend[b] = 0; m_sel[b] = 0; m_en[b] = 0; m_mask[b] = 0;
    end
    for (int k = 0; k < 4; k++) m_ctl[k] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 fiq", 32'(fiq), 0);
    for (int a = 0; a < 'h60; a += 4) begin
      peek(10'(a), d);
      chk("R1 reg", d, 0);
    end

    // R2: source 37 -> bank 1 bit 5, three-edge latency
    @(negedge clk);
    src[37] = 1'b1;
    @(negedge clk); @(negedge clk);
    peek(10'h14, d); chk("R2 early", d, 0);
    @(negedge clk);
    peek(10'h14, d); chk("R2 latched", d, 32'h20);
    src = '0;
    m_pend[1] = 32'h20;
    chk("R6 irq on pending", 32'(irq), 1);
    chk("R7 fiq unselected", 32'(fiq), 0);
    repeat (3) @(negedge clk);
    // R3: sticky after source drops
    peek(10'h14, d); chk("R3 sticky", d, 32'h20);
    wr(10'h14, 32'h20);
    peek(10'h14, d); chk("R4 cleared", d, 0);

    // R5: set wins against a clear while the source is high
    @(negedge clk);
    src[0] = 1'b1;
    repeat (3) @(negedge clk);
    wr(10'h10, 32'h1);
    peek(10'h10, d); chk("R5 set wins", d, 32'h1);
    src = '0;
    repeat (3) @(negedge clk);
    m_pend[0] = 32'h1;
    wr(10'h10, 32'h1);
    peek(10'h10, d); chk("R5 later clear", d, 0);

    // R4: partial clear leaves zero-data bits alone
    raise(95'h6);
    wr(10'h10, 32'h2);
    peek(10'h10, d); chk("R4 partial", d, 32'h4);
    wr(10'h10, 32'h4);

    // R12: all sources high, bank 2 bit 31 absent
    raise('1);
    peek(10'h18, d); chk("R12 bank2", d, 32'h7FFF_FFFF);
    peek(10'h10, d); chk("R2 bank0 full", d, 32'hFFFF_FFFF);
    chk("R6 irq all", 32'(irq), 1);
    wr(10'h50, 32'hFFFF_FFFF); wr(10'h54, 32'hFFFF_FFFF); wr(10'h58, 32'hFFFF_FFFF);
    chk("R6 all masked", 32'(irq), 0);
    wr(10'h38, 32'h4000_0000);
    chk("R7 sel but masked", 32'(fiq), 0);
    wr(10'h58, ~32'h4000_0000);
    chk("R6 one unmasked", 32'(irq), 1);
    chk("R7 fiq one", 32'(fiq), 1);
    wr(10'h38, 32'h0);
    chk("R7 deselected", 32'(fiq), 0);
    wr(10'h58, 32'h7FFF_FFFF);
    wr(10'h38, 32'h8000_0000);
    chk("R12 irq none", 32'(irq), 0);
    chk("R12 fiq none", 32'(fiq), 0);
    peek(10'h38, d); chk("R9 sel readback", d, 32'h8000_0000);

    // R9: enable stores but does not gate
    wr(10'h58, 32'h0);
    wr(10'h48, 32'hFFFF_FFFF);
    peek(10'h48, d); chk("R9 en readback", d, 32'hFFFF_FFFF);
    wr(10'h48, 32'h0);
    chk("R9 en no effect", 32'(irq), 1);

    // R10: fast-pending region
    wr(10'h20, 32'hFFFF_FFFF);
    peek(10'h20, d); chk("R10 reads zero", d, 0);
    peek(10'h10, d); chk("R10 no clear", d, 32'hFFFF_FFFF);

    // R11: unmapped and misaligned
    wr(10'h1C, 32'hFFFF_FFFF);
    wr(10'h5C, 32'h0);
    wr(10'h60, 32'hFFFF_FFFF);
    wr(10'h3FC, 32'hFFFF_FFFF);
    wr(10'h12, 32'hFFFF_FFFF);
    wr(10'h52, 32'h0);
    peek(10'h1C, d); chk("R11 bank3 read", d, 0);
    peek(10'h60, d); chk("R11 high read", d, 0);
    peek(10'h12, d); chk("R11 misaligned read", d, 0);
    peek(10'h10, d); chk("R11 pend kept", d, 32'hFFFF_FFFF);
    peek(10'h50, d); chk("R11 mask kept", d, 32'hFFFF_FFFF);

    // R8: control words, no fall-through between them
    wr(10'h08, 32'hDEAD_BEEF);
    wr(10'h04, 32'h1234_5677);
    wr(10'h00, 32'hFFFF_FFFF);
    wr(10'h0C, 32'h0000_0003);
    peek(10'h00, d); chk("R8 vector", d, 32'hFFFF_FFFC);
    peek(10'h04, d); chk("R8 base", d, 32'h1234_5674);
    peek(10'h08, d); chk("R8 protect kept", d, 32'hDEAD_BEEF);
    peek(10'h0C, d); chk("R8 nmi", d, 32'h0000_0003);

    // Return to a clean state, then random mix
    wr(10'h10, '1); wr(10'h14, '1); wr(10'h18, '1);
    wr(10'h50, 0); wr(10'h54, 0); wr(10'h58, 0);
    for (int it = 0; it < 80; it++) begin
      int op = int'($urandom % 5);
      int b  = int'($urandom % 3);
      logic [31:0] rv = $urandom;
      logic [9:0]  ra;
      case (op)
        0: begin
          logic [95:0] r1 = {$urandom, $urandom, $urandom};
          logic [95:0] r2 = {$urandom, $urandom, $urandom};
          logic [95:0] r3 = {$urandom, $urandom, $urandom};
          raise(r1[94:0] & r2[94:0] & r3[94:0]);
        end
        1: wr(10'(32'h50 + 4 * b), rv & $urandom);
        2: wr(10'(32'h30 + 4 * b), rv);
        3: wr(10'(32'h10 + 4 * b), rv);
        default: wr(10'({$urandom} % 256) << 2, rv);
      endcase
      chk("R6 random irq", 32'(irq), 32'(f_irq()));
      chk("R7 random fiq", 32'(fiq), 32'(f_fiq()));
      ra = 10'(($urandom % 32) * 4);
      peek(ra, d);
      chk("R9 random readback", d, exp_rd(ra));
    end
    finish_run();
  end
endmodule